// File: doc/BRIEF.md
# Fuse Array Read Sequencer

This block reads bytes out of a one-time-programmable fuse macro on behalf of a simple requester. The requester presents a byte offset and a byte count with a start pulse. The block first checks that the span lies inside the 128-byte array (32 words of 32 bits). It then drives the macro's control word through a fixed sequence: array-read mode, one timed strobe per covered word, and a return to the low-power state.

Each fetched word is split into bytes in little-endian order. The unwanted leading bytes of the first word and the unwanted trailing bytes of the last word are dropped, so the byte stream carries exactly the requested bytes. The stream uses a valid/ready handshake and marks its final byte. A one-cycle completion pulse ends every request and carries an error flag.

All waits are one microsecond long. They are counted in clock cycles, and the count comes from a clock-frequency parameter rounded up.

Top module: `fuse_rd_seq`

## Requirements
- R1: A request with `len` equal to 0 or with `offset + len` above 128 is rejected. The cycle after `start`, `done` and `err` are both high. No byte is emitted, `busy` stays low and `fuse_ctrl` stays at its power-down value 0x0000_0021.
- R2: An accepted request first writes the read-mode control word 0x0000_028C. This word has bit2 (load), bit3 (program-disable), bit7 (read-sense) and bit9 (strobe timing select) set and all other bits clear. It is held for exactly WAIT cycles before the first strobe.
- R3: During each word access, `fuse_ctrl` equals 0x028C plus bit1 (strobe) plus the word index in bits 25:16. Strobe stays high for exactly WAIT cycles, and the macro data word is captured on the last of those cycles.
- R4: After strobe falls, the word address stays in bits 25:16 and strobe stays low for at least WAIT+1 cycles before the next strobe.
- R5: The words fetched run in ascending order from `offset/4` up to, but not including, ceil((`offset`+`len`)/4). Each word is fetched exactly once.
- R6: The output bytes are array bytes `offset` … `offset+len-1` in order. Byte k of a word is data bits 8k+7:8k.
- R7: `out_last` is high with `out_valid` on the final byte only.
- R8: After the last word, `fuse_ctrl` becomes 0x0000_0021 (bit5 power-down, bit0 chip-select inactive). In the same cycle `done` pulses with `err` low.
- R9: While `out_valid` is high and `out_ready` is low, `fuse_ctrl` does not change and no byte is lost.
- R10: WAIT equals ceil(`CLK_HZ` / 1,000,000) cycles.
- R11: After reset, and after a reset that arrives during a read, `fuse_ctrl` is 0x0000_0021 and `busy`, `out_valid` and `done` are low.
- R12: `busy` is high from the cycle after an accepted `start` until the cycle of `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, sampled while idle |
| offset | input | 8 | First byte index |
| len | input | 8 | Number of bytes |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Rejection flag, valid with `done` |
| fuse_ctrl | output | 32 | Control word to the fuse macro |
| fuse_dout | input | 32 | Data word from the fuse macro |
| out_data | output | 8 | Stream byte |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Stream consumer ready |
| out_last | output | 1 | Final byte of the request |

## Verification
The main read path is tried with several request shapes:
- the full array;
- one aligned word;
- spans that start and end inside a single word;
- spans that cross one word boundary;
- spans that cover many words and end on the last array byte.

Each shape separates a different mistake in computing the first word, the end word or the trimming lane.

Rejected spans probe each bound of the range check, including a span that overruns by a single byte. Runs with a periodically stalled consumer show whether the control word freezes and bytes survive back-pressure. A non-integer microsecond clock count shows whether the wait rounds up.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;
  localparam int CB_CSN  = 0;
  localparam int CB_STB  = 1;
  localparam int CB_LOAD = 2;
  localparam int CB_PGMN = 3;
  localparam int CB_PDN  = 5;
  localparam int CB_SNS  = 7;
  localparam int CB_TSEL = 9;
  localparam int CA_LSB  = 16;
  localparam int CA_W    = 10;
  localparam int WORD_BYTES = 4;

  localparam logic [31:0] CTRL_OFF  = (32'(1) << CB_PDN) | (32'(1) << CB_CSN);
  localparam logic [31:0] CTRL_READ = (32'(1) << CB_LOAD) | (32'(1) << CB_PGMN) |
                                      (32'(1) << CB_TSEL) | (32'(1) << CB_SNS);
  localparam logic [31:0] CTRL_STB  = 32'(1) << CB_STB;

  typedef enum logic [2:0] {
    S_IDLE, S_ENTER, S_STRB, S_EMIT, S_RECOV
  } seq_state_e;
endpackage

// File: rtl/fuse_rd_delay.sv
module fuse_rd_delay #(
  parameter int CYCLES = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  output logic elapsed
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (kick) begin
      run <= 1'b1;
      cnt <= CW'(CYCLES - 1);
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign elapsed = run && (cnt == '0);

  // R10
  wait_len_chk: assert property (@(posedge clk) disable iff (rst)
    kick |=> (run && cnt == CW'(CYCLES - 1)));
endmodule

// File: rtl/fuse_rd_span.sv
module fuse_rd_span #(
  parameter int OFF_W = 8,
  parameter int WORDS = 32
) (
  input  logic [OFF_W-1:0] off,
  input  logic [OFF_W-1:0] cnt,
  output logic             ok,
  output logic [OFF_W-1:0] first_w,
  output logic [OFF_W-1:0] end_w,
  output logic [1:0]       lane0
);
  localparam int TOTAL = WORDS * fuse_rd_pkg::WORD_BYTES;

  logic [OFF_W:0]   sum;
  logic [OFF_W+1:0] up;

  always_comb begin
    sum     = {1'b0, off} + {1'b0, cnt};
    up      = {1'b0, sum} + (OFF_W+2)'(3);
    ok      = (cnt != '0) && (sum <= (OFF_W+1)'(TOTAL));
    first_w = off >> 2;
    end_w   = up[OFF_W+1:2];
    lane0   = off[1:0];
  end
endmodule

// File: rtl/fuse_rd_lane.sv
module fuse_rd_lane (
  input  logic [31:0] word,
  input  logic [1:0]  lane,
  output logic [7:0]  byte_o
);
  assign byte_o = word[8*lane +: 8];
endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq #(
  parameter int CLK_HZ = 100_000_000,
  parameter int WORDS  = 32,
  parameter int OFF_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [OFF_W-1:0] offset,
  input  logic [OFF_W-1:0] len,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [31:0]      fuse_ctrl,
  input  logic [31:0]      fuse_dout,
  output logic [7:0]       out_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_last
);
  import fuse_rd_pkg::*;

  localparam int WAIT = (CLK_HZ + 999_999) / 1_000_000;

  seq_state_e       st;
  logic [31:0]      ctrl_q, word_q;
  logic [OFF_W-1:0] word_idx, end_q, remain;
  logic [1:0]       lane_q;
  logic             span_ok, tmr_el, kick, emit_end;
  logic [OFF_W-1:0] span_first, span_end;
  logic [1:0]       span_lane;
  logic [7:0]       cap_byte, nxt_byte;

  function automatic logic [31:0] addr_word(input logic [OFF_W-1:0] w);
    return CTRL_READ | (32'(CA_W'(w)) << CA_LSB);
  endfunction

  fuse_rd_span #(.OFF_W(OFF_W), .WORDS(WORDS)) span_i (
    .off(offset), .cnt(len), .ok(span_ok),
    .first_w(span_first), .end_w(span_end), .lane0(span_lane)
  );

  fuse_rd_delay #(.CYCLES(WAIT)) dly_i (
    .clk(clk), .rst(rst), .kick(kick), .elapsed(tmr_el)
  );

  fuse_rd_lane cap_lane_i (.word(fuse_dout), .lane(lane_q),        .byte_o(cap_byte));
  fuse_rd_lane nxt_lane_i (.word(word_q),    .lane(lane_q + 2'd1), .byte_o(nxt_byte));

  assign emit_end = (remain == OFF_W'(1)) || (lane_q == 2'd3);

  always_comb begin
    kick = 1'b0;
    case (st)
      S_IDLE:  kick = start && span_ok;
      S_ENTER: kick = tmr_el;
      S_EMIT:  kick = out_ready && emit_end;
      S_RECOV: kick = tmr_el && (remain != '0);
      default: kick = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      ctrl_q    <= CTRL_OFF;
      word_q    <= '0;
      word_idx  <= '0;
      end_q     <= '0;
      remain    <= '0;
      lane_q    <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      out_data  <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (!span_ok) begin
            done <= 1'b1;
            err  <= 1'b1;
          end else begin
            busy     <= 1'b1;
            ctrl_q   <= CTRL_READ;
            word_idx <= span_first;
            end_q    <= span_end;
            lane_q   <= span_lane;
            remain   <= len;
            st       <= S_ENTER;
          end
        end
        S_ENTER: if (tmr_el) begin
          ctrl_q <= addr_word(word_idx) | CTRL_STB;
          st     <= S_STRB;
        end
        S_STRB: if (tmr_el) begin
          word_q    <= fuse_dout;
          ctrl_q    <= addr_word(word_idx);
          out_valid <= 1'b1;
          out_data  <= cap_byte;
          out_last  <= (remain == OFF_W'(1));
          st        <= S_EMIT;
        end
        S_EMIT: if (out_ready) begin
          remain <= remain - 1'b1;
          if (emit_end) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            lane_q    <= '0;
            word_idx  <= word_idx + 1'b1;
            st        <= S_RECOV;
          end else begin
            lane_q   <= lane_q + 2'd1;
            out_data <= nxt_byte;
            out_last <= (remain == OFF_W'(2));
          end
        end
        S_RECOV: if (tmr_el) begin
          if (remain == '0) begin
            ctrl_q <= CTRL_OFF;
            done   <= 1'b1;
            busy   <= 1'b0;
            st     <= S_IDLE;
          end else begin
            ctrl_q <= addr_word(word_idx) | CTRL_STB;
            st     <= S_STRB;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign fuse_ctrl = ctrl_q;

  // R9
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> $stable(fuse_ctrl));
  // R7
  last_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);
  // R8
  done_pd_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (fuse_ctrl == CTRL_OFF && !out_valid));
  // R5
  end_match_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_RECOV) |-> ((remain == '0) == (word_idx == end_q)));
  // R3
  stb_mode_chk: assert property (@(posedge clk) disable iff (rst)
    fuse_ctrl[CB_STB] |-> (fuse_ctrl[CB_LOAD] && !fuse_ctrl[CB_PDN]));
  // R12
  busy_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/fuse_rd_seq_tb_top.sv
`timescale 1ns/1ps
module fuse_rd_seq_tb_top;
  localparam int TB_HZ = 12_500_000;
  localparam int W_EXP = 13;   // 12.5 cycles per microsecond, rounded up

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  offset = '0, len = '0;
  logic        busy, done, err, out_valid, out_last;
  logic        out_ready = 1'b1;
  logic [31:0] fuse_ctrl, fuse_dout;
  logic [7:0]  out_data;

  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  fuse_rd_seq #(.CLK_HZ(TB_HZ)) dut_i (
    .clk(clk), .rst(rst), .start(start), .offset(offset), .len(len),
    .busy(busy), .done(done), .err(err), .fuse_ctrl(fuse_ctrl),
    .fuse_dout(fuse_dout), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_last(out_last)
  );

  function automatic logic [7:0] fbyte(input int b);
    return 8'((b * 37 + 11) & 255);
  endfunction

  // Fuse macro model: data is only driven while strobed in read mode
  always_comb begin
    if (fuse_ctrl[1] && (fuse_ctrl & ~32'h03FF_0002) == 32'h0000_028C) begin
      int a;
      a = int'(fuse_ctrl[25:16]);
      fuse_dout = {fbyte(4*a+3), fbyte(4*a+2), fbyte(4*a+1), fbyte(4*a)};
    end else begin
      fuse_dout = 32'hDEAD_BEEF;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor state
  int  enter_cnt, hi_cnt, lo_cnt, w_min, w_max, gap_min, pulses, exp_addr;
  int  addr_err, enc_err, hold_err, busy_err, byte_err, last_err, got;
  bit  prev_stb, prev_stall, moved;
  logic [31:0] prev_ctrl;

  task automatic observe();
    bit stb;
    stb = fuse_ctrl[1];
    if (fuse_ctrl != 32'h21) moved = 1;
    if (fuse_ctrl == 32'h28C && pulses == 0) enter_cnt++;
    if (stb) begin
      if ((fuse_ctrl & ~32'h03FF_0002) != 32'h28C) enc_err++;
      if (!prev_stb) begin
        if (int'(fuse_ctrl[25:16]) != exp_addr) addr_err++;
        if (pulses > 0 && lo_cnt < gap_min) gap_min = lo_cnt;
        exp_addr++;
        pulses++;
        hi_cnt = 0;
      end
      hi_cnt++;
    end else if (prev_stb) begin
      if (hi_cnt < w_min) w_min = hi_cnt;
      if (hi_cnt > w_max) w_max = hi_cnt;
      if (fuse_ctrl[25:16] != prev_ctrl[25:16]) enc_err++;
      lo_cnt = 1;
    end else begin
      lo_cnt++;
    end
    if (prev_stall && fuse_ctrl != prev_ctrl) hold_err++;
    prev_stall = out_valid && !out_ready;
    prev_stb = stb;
    prev_ctrl = fuse_ctrl;
  endtask

  task automatic run_req(input int off, input int n, input bit stall, input bit bad);
    int cyc;
    bit fin, e_seen;
    logic [31:0] ctrl_at_done;
    int first_w, end_w;
    enter_cnt = 0; hi_cnt = 0; lo_cnt = 0; w_min = 1 << 30; w_max = 0;
    gap_min = 1 << 30; pulses = 0; addr_err = 0; enc_err = 0; hold_err = 0;
    busy_err = 0; byte_err = 0; last_err = 0; got = 0;
    prev_stb = 0; prev_stall = 0; moved = 0; prev_ctrl = fuse_ctrl;
    first_w = off / 4; end_w = (off + n + 3) / 4; exp_addr = first_w;
    cyc = 0; fin = 0; e_seen = 0; ctrl_at_done = '0;
    @(negedge clk);
    offset = 8'(off); len = 8'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!fin && cyc < 20000) begin
      cyc++;
      out_ready = stall ? (cyc % 3 != 0) : 1'b1;
      observe();
      if (out_valid && out_ready) begin
        if (out_data != fbyte(off + got)) byte_err++;
        if (out_last != (got == n - 1)) last_err++;
        got++;
      end
      if (done) begin
        fin = 1; e_seen = err; ctrl_at_done = fuse_ctrl;
      end else if (!busy && !bad) busy_err++;
      if (!fin) @(negedge clk);
    end
    out_ready = 1'b1;
    chk(fin, "R1", "request finished", fin, 1);
    if (bad) begin
      chk(e_seen == 1, "R1", "reject err", e_seen, 1);
      chk(cyc == 1, "R1", "reject latency", cyc, 1);
      chk(got == 0 && !moved, "R1", "reject no activity", got, 0);
    end else begin
      chk(e_seen == 0, "R8", "err on success", e_seen, 0);
      chk(ctrl_at_done == 32'h21, "R8", "power-down word", ctrl_at_done, 32'h21);
      chk(enter_cnt == W_EXP, "R2", "read-mode lead", enter_cnt, W_EXP);
      chk(w_min == W_EXP && w_max == W_EXP, "R3", "strobe width", w_max, W_EXP);
      chk(w_min == W_EXP, "R10", "rounded wait", w_min, W_EXP);
      chk(enc_err == 0, "R3", "strobe encoding", enc_err, 0);
      if (pulses > 1) chk(gap_min >= W_EXP + 1, "R4", "recovery gap", gap_min, W_EXP + 1);
      chk(pulses == end_w - first_w, "R5", "word count", pulses, end_w - first_w);
      chk(addr_err == 0, "R5", "word order", addr_err, 0);
      chk(got == n, "R6", "byte count", got, n);
      chk(byte_err == 0, "R6", "byte values", byte_err, 0);
      chk(last_err == 0, "R7", "last marker", last_err, 0);
      chk(hold_err == 0, "R9", "ctrl held in stall", hold_err, 0);
      chk(busy_err == 0, "R12", "busy during read", busy_err, 0);
    end
    repeat (3) @(negedge clk);
  endtask

  // {offset, len, stall, reject}
  localparam int NV = 13;
  localparam logic [17:0] VEC [NV] = '{
    {8'd0,   8'd128, 1'b0, 1'b0},
    {8'd0,   8'd4,   1'b0, 1'b0},
    {8'd1,   8'd2,   1'b1, 1'b0},
    {8'd3,   8'd2,   1'b0, 1'b0},
    {8'd5,   8'd9,   1'b1, 1'b0},
    {8'd124, 8'd4,   1'b0, 1'b0},
    {8'd127, 8'd1,   1'b1, 1'b0},
    {8'd2,   8'd1,   1'b0, 1'b0},
    {8'd10,  8'd30,  1'b1, 1'b0},
    {8'd0,   8'd0,   1'b0, 1'b1},
    {8'd100, 8'd29,  1'b0, 1'b1},
    {8'd200, 8'd1,   1'b0, 1'b1},
    {8'd127, 8'd2,   1'b0, 1'b1}
  };

  initial begin
    #2_000_000;
    fails++;
    tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(fuse_ctrl == 32'h21, "R11", "ctrl after reset", fuse_ctrl, 32'h21);
    chk(!busy && !out_valid && !done, "R11", "idle flags after reset",
        {busy, out_valid, done}, 0);

    for (int i = 0; i < NV; i++)
      run_req(int'(VEC[i][17:10]), int'(VEC[i][9:2]), VEC[i][1], VEC[i][0]);

    // R11 reset in the middle of a read
    @(negedge clk);
    offset = 8'd0; len = 8'd64; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(fuse_ctrl == 32'h21, "R11", "ctrl after mid-read reset", fuse_ctrl, 32'h21);
    chk(!busy && !out_valid && !done, "R11", "flags after mid-read reset",
        {busy, out_valid, done}, 0);

    // recovery after reset: a fresh unaligned read still works
    run_req(6, 7, 1'b0, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule